// File: doc/BRIEF.md
# Deferred Output Load Gate

This block decides when the per-channel result registers of a multi-channel converter are copied into its output registers. A host asks for a copy by taking an active-low load strobe low. The copy happens only when both the local arithmetic sequencer and every other device sharing an open-drain "not ready" line have finished. A request made too early is remembered and carried out later. If the strobe is held low, a copy follows every return to ready.

Each channel has a dirty flag. A channel is refreshed only if one of its result registers was written since its last refresh. With each refresh the gate passes on that channel's A/B choice, so the output stage knows which result to take. An active-low clear input forces the outputs to their ground reference. While it is low, every load strobe is dropped. No stored state is lost, so the earlier outputs come back once the clear is released.

The load strobe, the clear and the shared line are asynchronous. Each passes through a two-flop synchroniser before any edge is detected.

Top module: `ldg_gate`

## Requirements
- R1: After a falling edge on `ldac_n_i` while ready (local busy high and shared line high) and `clr_n_i` high, `ld_o` carries exactly one single-cycle pulse. The pulse has a 1 in bit i for each channel i whose dirty flag is set.
- R2: A falling edge on `ldac_n_i` while the local busy input is low causes no load then. It is held pending and executed once ready returns.
- R3: While `ldac_n_i` stays low, a load is issued each time the ready condition rises.
- R4: A low shared line `busy_line_n_i` holds off any load, even when the local sequencer is idle. The pending load runs after the line is released.
- R5: Only dirty channels are loaded. A load request with no dirty channel produces no pulse, and a pulse clears the flags of the channels it loads.
- R6: In the cycle a channel's `ld_o` bit is 1, its `ld_sel_b_o` bit equals that channel's `sel_b_i` (1 = take result B, 0 = result A). Between loads, `ld_sel_b_o` does not change.
- R7: If a result-write pulse and a load for the same channel fall in the same cycle, the flag stays set: that load skips the channel, and the next load includes it.
- R8: While the synchronised `clr_n_i` is low, `clr_force_o` is 1 and no `ld_o` bit is set. A load strobe seen during the clear is discarded and does not run after the clear ends.
- R9: A clear does not lose dirty flags. Channels written before or during a clear are loaded by the first load request after it ends.
- R10: `busy_pull_o` is 1 exactly while `busy_loc_n_i` is low, so the block pulls the shared line.
- R11: After reset, `ld_o` is all zero and `clr_force_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldac_n_i | input | 1 | Asynchronous active-low load strobe |
| clr_n_i | input | 1 | Asynchronous active-low clear |
| busy_loc_n_i | input | 1 | Local sequencer idle flag (low = computing) |
| busy_line_n_i | input | 1 | Shared wired-AND ready line (low = some device busy) |
| busy_pull_o | output | 1 | Pull-down enable for the shared line |
| wr_pulse_i | input | NCH | Per-channel result-written pulse |
| sel_b_i | input | NCH | Per-channel A/B choice |
| ld_o | output | NCH | Per-channel output-register load pulse |
| ld_sel_b_o | output | NCH | A/B choice passed with each load |
| clr_force_o | output | 1 | Force outputs to ground reference |

## Verification
The load path is tested with strobes that arrive while ready, while the local sequencer is busy, and while only a foreign device holds the shared line. Together these separate immediate from deferred execution and local from shared hold-off. A strobe held low across several busy periods separates edge-triggered from level-triggered loading. Strobes with no writes in between, and a write that lands in the very cycle of a load, show whether the dirty flags are cleared and kept at the right moments. Strobes inside a clear, followed by a strobe after it, show that requests are dropped while the flags survive.

// File: rtl/ldg_pkg.sv
package ldg_pkg;

    // synchronised control levels, all active-high after inversion
    typedef struct packed {
        logic ldac_low;
        logic clr_low;
        logic line_free;
    } ldg_ctl_t;

    // reset pattern of the raw (active-low style) synchroniser inputs:
    // strobe high, clear high, line released
    localparam logic [2:0] LDG_SYNC_RST = 3'b111;

    typedef enum logic [1:0] {
        LDG_IDLE    = 2'd0,
        LDG_PENDING = 2'd1
    } ldg_req_e;

    function automatic logic ldg_rise(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/ldg_sync.sv
module ldg_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1,
    parameter int          STAGES  = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= RST_VAL;
                    else     chain_q[s] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= RST_VAL;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/ldg_event.sv
module ldg_event
    import ldg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ldg_ctl_t ctl_i,
    input  logic     loc_free_i,
    output logic     fire_o,
    output logic     clr_force_o
);
    logic     ldac_low_q;
    logic     ready_q;
    ldg_req_e req_q;
    ldg_req_e req_d;

    logic ready;
    logic strobe_fall;
    logic ready_rise;
    logic trigger;

    assign ready       = loc_free_i & ctl_i.line_free;
    assign strobe_fall = ldg_rise(ctl_i.ldac_low, ldac_low_q);
    assign ready_rise  = ldg_rise(ready, ready_q);
    assign trigger     = strobe_fall | (ctl_i.ldac_low & ready_rise);

    assign fire_o = ~ctl_i.clr_low & ready & (trigger | (req_q == LDG_PENDING));
    assign clr_force_o = ctl_i.clr_low;

    always_comb begin
        req_d = req_q;
        if (ctl_i.clr_low)  req_d = LDG_IDLE;
        else if (fire_o)    req_d = LDG_IDLE;
        else if (trigger)   req_d = LDG_PENDING;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ldac_low_q <= 1'b0;
            ready_q    <= 1'b0;
            req_q      <= LDG_IDLE;
        end else begin
            ldac_low_q <= ctl_i.ldac_low;
            ready_q    <= ready;
            req_q      <= req_d;
        end
    end
endmodule

// File: rtl/ldg_chan_bank.sv
module ldg_chan_bank #(
    parameter int NCH = 40
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           fire_i,
    input  logic [NCH-1:0] wr_pulse_i,
    input  logic [NCH-1:0] sel_b_i,
    output logic [NCH-1:0] ld_o,
    output logic [NCH-1:0] ld_sel_b_o
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            logic dirty_q;
            logic take;

            assign take = fire_i & dirty_q;

            always_ff @(posedge clk) begin
                if (rst) begin
                    dirty_q       <= 1'b0;
                    ld_o[c]       <= 1'b0;
                    ld_sel_b_o[c] <= 1'b0;
                end else begin
                    ld_o[c] <= take;
                    if (take) ld_sel_b_o[c] <= sel_b_i[c];
                    // a write in the load cycle keeps the flag set
                    dirty_q <= wr_pulse_i[c] | (dirty_q & ~fire_i);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ldg_gate.sv
module ldg_gate
    import ldg_pkg::*;
#(
    parameter int NCH = 40
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ldac_n_i,
    input  logic           clr_n_i,
    input  logic           busy_loc_n_i,
    input  logic           busy_line_n_i,
    output logic           busy_pull_o,
    input  logic [NCH-1:0] wr_pulse_i,
    input  logic [NCH-1:0] sel_b_i,
    output logic [NCH-1:0] ld_o,
    output logic [NCH-1:0] ld_sel_b_o,
    output logic           clr_force_o
);
    logic [2:0] raw_sync;
    ldg_ctl_t   ctl;
    logic       fire;

    ldg_sync #(
        .W       (3),
        .RST_VAL (LDG_SYNC_RST),
        .STAGES  (2)
    ) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i ({ldac_n_i, clr_n_i, busy_line_n_i}),
        .sync_o  (raw_sync)
    );

    assign ctl.ldac_low  = ~raw_sync[2];
    assign ctl.clr_low   = ~raw_sync[1];
    assign ctl.line_free =  raw_sync[0];

    ldg_event event_i (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (ctl),
        .loc_free_i  (busy_loc_n_i),
        .fire_o      (fire),
        .clr_force_o (clr_force_o)
    );

    ldg_chan_bank #(.NCH(NCH)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .fire_i     (fire),
        .wr_pulse_i (wr_pulse_i),
        .sel_b_i    (sel_b_i),
        .ld_o       (ld_o),
        .ld_sel_b_o (ld_sel_b_o)
    );

    assign busy_pull_o = ~busy_loc_n_i;
endmodule

// File: rtl/ldg_gate_chk.sv
module ldg_gate_chk #(
    parameter int NCH = 40
) (
    input logic           clk,
    input logic           rst,
    input logic           busy_loc_n_i,
    input logic [NCH-1:0] ld_o,
    input logic [NCH-1:0] ld_sel_b_o,
    input logic           clr_force_o
);
    AST_LOAD_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
        (|ld_o) |=> (ld_o == '0)); // R1

    AST_LOAD_NEEDS_LOCAL_IDLE: assert property (@(posedge clk) disable iff (rst)
        (|ld_o) |-> $past(busy_loc_n_i)); // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ld_o == '0) |-> $stable(ld_sel_b_o)); // R6

    AST_CLEAR_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (|ld_o) |-> !$past(clr_force_o)); // R8
endmodule

bind ldg_gate ldg_gate_chk #(.NCH(NCH)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .busy_loc_n_i (busy_loc_n_i),
    .ld_o         (ld_o),
    .ld_sel_b_o   (ld_sel_b_o),
    .clr_force_o  (clr_force_o)
);

// File: tb/ldg_gate_tb.sv
module ldg_gate_tb_top;
    localparam int N = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ldac_n = 1'b1;
    logic         clr_n = 1'b1;
    logic         busy_loc_n = 1'b1;
    logic         ext_free = 1'b1;
    logic         busy_line_n;
    logic         busy_pull;
    logic [N-1:0] wr = '0;
    logic [N-1:0] sel_b;
    logic [N-1:0] ld;
    logic [N-1:0] ld_sel;
    logic         clr_force;

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    string cur_req = "R1";

    typedef struct {
        logic [N-1:0] mask;
        logic [N-1:0] sel;
        string        req;
    } exp_t;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    // wired-AND line: this block's pull plus a foreign device
    assign busy_line_n = busy_pull ? 1'b0 : ext_free;

    ldg_gate #(.NCH(N)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .ldac_n_i      (ldac_n),
        .clr_n_i       (clr_n),
        .busy_loc_n_i  (busy_loc_n),
        .busy_line_n_i (busy_line_n),
        .busy_pull_o   (busy_pull),
        .wr_pulse_i    (wr),
        .sel_b_i       (sel_b),
        .ld_o          (ld),
        .ld_sel_b_o    (ld_sel),
        .clr_force_o   (clr_force)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic expect_load(input logic [N-1:0] m, input string req);
        exp_t e;
        e.mask = m;
        e.sel  = sel_b & m;
        e.req  = req;
        sb_q.push_back(e);
    endtask

    task automatic write_ch(input logic [N-1:0] m);
        @(negedge clk); wr = m;
        @(negedge clk); wr = '0;
    endtask

    task automatic pulse_ldac();
        @(negedge clk); ldac_n = 1'b0;
        repeat (2) @(negedge clk);
        ldac_n = 1'b1;
    endtask

    task automatic idle_check(input string req);
        repeat (10) @(negedge clk);
        chk(sb_q.size() == 0, req, 64'(sb_q.size()), 64'd0);
    endtask

    // monitor: every load pulse must match the next expected item
    always @(negedge clk) begin
        if (!rst && ld != '0) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, cur_req, 64'(ld), 64'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(ld == e.mask, e.req, 64'(ld), 64'(e.mask));
                chk((ld_sel & e.mask) == e.sel, "R6", 64'(ld_sel & e.mask), 64'(e.sel));
            end
        end
    end

    initial begin
        sel_b = '0;
        sel_b[17] = 1'b1;
        sel_b[11] = 1'b1;
        sel_b[20] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(ld == '0, "R11", 64'(ld), 64'd0);
        chk(clr_force == 1'b0, "R11", 64'(clr_force), 64'd0);
        chk(busy_pull == 1'b0, "R10", 64'(busy_pull), 64'd0);

        // R1 / R5: immediate load of two dirty channels
        cur_req = "R1";
        write_ch((N'(1) << 3) | (N'(1) << 17));
        expect_load((N'(1) << 3) | (N'(1) << 17), "R1");
        pulse_ldac();
        idle_check("R1");

        // R5: strobe with nothing dirty gives no pulse
        cur_req = "R5";
        pulse_ldac();
        idle_check("R5");

        // R2: local busy defers the load
        cur_req = "R2";
        @(negedge clk); busy_loc_n = 1'b0;
        @(negedge clk);
        chk(busy_pull == 1'b1, "R10", 64'(busy_pull), 64'd1);
        write_ch(N'(1) << 5);
        expect_load(N'(1) << 5, "R2");
        pulse_ldac();
        repeat (10) @(negedge clk);
        chk(sb_q.size() == 1, "R2", 64'(sb_q.size()), 64'd1);
        busy_loc_n = 1'b1;
        idle_check("R2");

        // R4: foreign device holds the shared line
        cur_req = "R4";
        @(negedge clk); ext_free = 1'b0;
        write_ch(N'(1) << 7);
        expect_load(N'(1) << 7, "R4");
        pulse_ldac();
        repeat (10) @(negedge clk);
        chk(sb_q.size() == 1, "R4", 64'(sb_q.size()), 64'd1);
        ext_free = 1'b1;
        idle_check("R4");

        // R3: strobe held low, a load per ready rise
        cur_req = "R3";
        @(negedge clk); ldac_n = 1'b0;
        repeat (6) @(negedge clk);
        busy_loc_n = 1'b0;
        write_ch(N'(1) << 9);
        expect_load(N'(1) << 9, "R3");
        repeat (3) @(negedge clk);
        busy_loc_n = 1'b1;
        idle_check("R3");
        busy_loc_n = 1'b0;
        write_ch(N'(1) << 10);
        expect_load(N'(1) << 10, "R3");
        repeat (3) @(negedge clk);
        busy_loc_n = 1'b1;
        idle_check("R3");

        // R7: write lands in the load cycle
        cur_req = "R7";
        @(negedge clk); busy_loc_n = 1'b0;
        write_ch(N'(1) << 12);
        expect_load(N'(1) << 12, "R7");
        repeat (3) @(negedge clk);
        busy_loc_n = 1'b1;          // n0
        @(negedge clk);             // n1
        @(negedge clk); wr = N'(1) << 11;   // n2: held across the fire edge
        @(negedge clk); wr = '0;
        idle_check("R7");
        busy_loc_n = 1'b0;
        expect_load(N'(1) << 11, "R7");
        repeat (3) @(negedge clk);
        busy_loc_n = 1'b1;
        idle_check("R7");
        @(negedge clk); ldac_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8: clear forces outputs and drops strobes
        cur_req = "R8";
        clr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(clr_force == 1'b1, "R8", 64'(clr_force), 64'd1);
        write_ch(N'(1) << 20);
        pulse_ldac();
        repeat (6) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(clr_force == 1'b0, "R8", 64'(clr_force), 64'd0);
        idle_check("R8");

        // R9: the flag written during the clear survives
        cur_req = "R9";
        expect_load(N'(1) << 20, "R9");
        pulse_ldac();
        idle_check("R9");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(1'b0, "watchdog", 64'd0, 64'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule